// File: doc/BRIEF.md
# Dual-Interrupt GPIO Bank

A bank of up to 32 general-purpose pins behind a word-wide register port. Each pin is an input or an output. Every input pin can flag an event on a rising edge, a falling edge, a low level or a high level, in any combination. A flagged event sets the pin's bit in two status registers at the same time. Each status register has its own enable register and drives its own interrupt line, so two consumers can watch different subsets of the same pins.

Writes may cover all four byte lanes or only some of them. Ordinary registers keep the bytes that were not written. Write-one-to-clear registers and the atomic set and clear aliases act only on the written bytes. A system configuration register offers a soft reset and gates a one-cycle wakeup pulse that fires when a wakeup-masked pin raises a new event. Debounce enable and debounce time are kept as plain storage. Reads are combinational from the register state.

Top module: `gpio_bank`

## Requirements
- R1: After reset: direction (0x34) reads all ones (every pin an input), 0x30 reads 2, both status registers (0x18, 0x28) and both enable registers (0x1C, 0x2C) read 0, 0x00 reads the REV_ID parameter, 0x14 reads 1, and both interrupt lines are low.
- R2: With rising-edge enable (0x48) or falling-edge enable (0x4C) set for an input pin, that transition sets the pin's bit in both 0x18 and 0x28.
- R3: With low-level enable (0x40) or high-level enable (0x44) set for an input pin, that level sets the pin's bit in both status registers.
- R4: A pin whose direction bit is 0 never sets status. pinOut equals output data (0x3C), and pinOe bit k is the inverse of direction bit k.
- R5: Writing 1 to a bit of 0x18 or 0x28 clears it. If the pin's level condition is still active (after a status clear, a level-enable write or a direction write), the bit is set again.
- R6: irqLine0 is high when any bit of 0x18 AND 0x1C is set. irqLine1 is high when any bit of 0x28 AND 0x2C is set. The two lines are independent.
- R7: Writing 1s to 0x60/0x64 clears/sets bits of 0x1C. 0x70/0x74 do the same for 0x2C, 0x80/0x84 for the wakeup mask (0x20), and 0x90/0x94 for output data.
- R8: busByteEn bit b enables bus bits 8b+7..8b. Ordinary registers keep the bits of disabled lanes. For status clears and aliases, the disabled lanes count as zero.
- R9: Configuration (0x10) stores the written value ANDed with 0x1D. A write with bit 1 set first returns every register except the input synchronizer to its reset value, which includes 0x30.
- R10: wakeReq pulses high for one cycle after a pin sets a status bit that was clear, but only when configuration bit 2 is 1, configuration bits 4:3 are nonzero, and the pin's wakeup-mask bit is 1.
- R11: 0x38 returns the pins through a two-flop synchronizer: a change becomes visible after the second rising edge. Writes to 0x38 are ignored. 0x50 stores PINS bits and 0x54 stores DBT_W bits without any effect on pin behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busAddr | input | 8 | Word-aligned byte address |
| busWdata | input | 32 | Write data, lane-aligned |
| busByteEn | input | 4 | Byte-lane enables for writes |
| busRdata | output | 32 | Combinational read data |
| pinIn | input | PINS | Asynchronous pin inputs |
| pinOut | output | PINS | Output data to pins |
| pinOe | output | PINS | Output enable per pin |
| irqLine0 | output | 1 | Interrupt line 0 |
| irqLine1 | output | 1 | Interrupt line 1 |
| wakeReq | output | 1 | One-cycle wakeup request |

## Verification
The bench builds the bank with PINS = 32, DBT_W = 8 and its default REV_ID, so every bus bit maps onto a pin. This lets single-lane writes hit both the pin-wide registers and the narrow configuration fields. With the full width, the bench also puts edge, level, output-only and wakeup pins in separate bit positions of one register and checks that enabling one bit does not disturb its neighbours.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_REV, SEL_SYSSTAT, SEL_CFG, SEL_ST0, SEL_EN0, SEL_WAKE,
    SEL_ST1, SEL_EN1, SEL_CFG2, SEL_DIR, SEL_DIN, SEL_DOUT, SEL_LO, SEL_HI,
    SEL_RISE, SEL_FALL, SEL_DBEN, SEL_DBT
  } regSel_e;

  typedef struct packed {
    logic cfg;    logic cfg2;   logic dir;    logic dout;
    logic st0Clr; logic st1Clr; logic en0;    logic en1;
    logic wake;   logic lo;     logic hi;     logic rise;
    logic fall;   logic dbEn;   logic dbTime;
    logic en0Clr; logic en0Set; logic en1Clr; logic en1Set;
    logic wakeClr; logic wakeSet; logic doutClr; logic doutSet;
  } wrStrobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regSel_e           regSel,
  output wrStrobe_t         stb
);
  logic wr;
  assign wr = busWrEn && (busAddr[1:0] == 2'b00);

  always_comb begin
    stb    = '0;
    regSel = SEL_NONE;
    case (busAddr)
      8'h00: regSel = SEL_REV;
      8'h10: begin regSel = SEL_CFG;  stb.cfg    = wr; end
      8'h14: regSel = SEL_SYSSTAT;
      8'h18: begin regSel = SEL_ST0;  stb.st0Clr = wr; end
      8'h1C: begin regSel = SEL_EN0;  stb.en0    = wr; end
      8'h20: begin regSel = SEL_WAKE; stb.wake   = wr; end
      8'h28: begin regSel = SEL_ST1;  stb.st1Clr = wr; end
      8'h2C: begin regSel = SEL_EN1;  stb.en1    = wr; end
      8'h30: begin regSel = SEL_CFG2; stb.cfg2   = wr; end
      8'h34: begin regSel = SEL_DIR;  stb.dir    = wr; end
      8'h38: regSel = SEL_DIN;
      8'h3C: begin regSel = SEL_DOUT; stb.dout   = wr; end
      8'h40: begin regSel = SEL_LO;   stb.lo     = wr; end
      8'h44: begin regSel = SEL_HI;   stb.hi     = wr; end
      8'h48: begin regSel = SEL_RISE; stb.rise   = wr; end
      8'h4C: begin regSel = SEL_FALL; stb.fall   = wr; end
      8'h50: begin regSel = SEL_DBEN; stb.dbEn   = wr; end
      8'h54: begin regSel = SEL_DBT;  stb.dbTime = wr; end
      8'h60: begin regSel = SEL_EN0;  stb.en0Clr = wr; end
      8'h64: begin regSel = SEL_EN0;  stb.en0Set = wr; end
      8'h70: begin regSel = SEL_EN1;  stb.en1Clr = wr; end
      8'h74: begin regSel = SEL_EN1;  stb.en1Set = wr; end
      8'h80: begin regSel = SEL_WAKE; stb.wakeClr = wr; end
      8'h84: begin regSel = SEL_WAKE; stb.wakeSet = wr; end
      8'h90: begin regSel = SEL_DOUT; stb.doutClr = wr; end
      8'h94: begin regSel = SEL_DOUT; stb.doutSet = wr; end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int         PINS   = 32,
  parameter int         DBT_W  = 8,
  parameter logic [7:0] REV_ID = 8'h21
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        stb,
  input  regSel_e          regSel,
  input  logic [BUS_W-1:0] busWdata,
  input  logic [3:0]       busByteEn,
  input  logic [PINS-1:0]  pinIn,
  output logic [BUS_W-1:0] busRdata,
  output logic [PINS-1:0]  pinOut,
  output logic [PINS-1:0]  pinOe,
  output logic             irqLine0,
  output logic             irqLine1,
  output logic             wakeReq,
  output logic [PINS-1:0]  statusLine0,
  output logic [PINS-1:0]  dirBits,
  output logic             wakeAllowed,
  output logic             softRst
);
  localparam logic [4:0] CFG_KEEP = 5'h1D;

  logic [4:0] cfg;
  logic [2:0] cfg2;
  logic [DBT_W-1:0] dbTime;
  logic [PINS-1:0] st0, st1, en0, en1, wakeMask, dir, dout;
  logic [PINS-1:0] loEn, hiEn, riseEn, fallEn, dbEn;
  logic [PINS-1:0] syncA, syncB, prevB, evt;
  logic [BUS_W-1:0] laneMask, curVal, merged, plain;

  genvar b;
  generate
    for (b = 0; b < BUS_W / 8; b++) begin : g_lane
      assign laneMask[8*b +: 8] = {8{busByteEn[b]}};
    end
  endgenerate

  always_comb begin
    curVal = '0;
    case (regSel)
      SEL_REV:     curVal[7:0] = REV_ID;
      SEL_SYSSTAT: curVal[0] = 1'b1;
      SEL_CFG:     curVal[4:0] = cfg;
      SEL_ST0:     curVal[PINS-1:0] = st0;
      SEL_EN0:     curVal[PINS-1:0] = en0;
      SEL_WAKE:    curVal[PINS-1:0] = wakeMask;
      SEL_ST1:     curVal[PINS-1:0] = st1;
      SEL_EN1:     curVal[PINS-1:0] = en1;
      SEL_CFG2:    curVal[2:0] = cfg2;
      SEL_DIR:     curVal[PINS-1:0] = dir;
      SEL_DIN:     curVal[PINS-1:0] = syncB;
      SEL_DOUT:    curVal[PINS-1:0] = dout;
      SEL_LO:      curVal[PINS-1:0] = loEn;
      SEL_HI:      curVal[PINS-1:0] = hiEn;
      SEL_RISE:    curVal[PINS-1:0] = riseEn;
      SEL_FALL:    curVal[PINS-1:0] = fallEn;
      SEL_DBEN:    curVal[PINS-1:0] = dbEn;
      SEL_DBT:     curVal[DBT_W-1:0] = dbTime;
      default: ;
    endcase
  end

  assign busRdata = curVal;
  assign plain    = busWdata & laneMask;
  assign merged   = (curVal & ~laneMask) | plain;
  assign softRst  = stb.cfg && merged[1];

  assign evt = dir & ((syncB & ~prevB & riseEn) | (~syncB & prevB & fallEn) |
                      (syncB & hiEn) | (~syncB & loEn));
  assign wakeAllowed = cfg[2] && (cfg[4:3] != 2'b00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0; syncB <= '0; prevB <= '0;
    end else begin
      syncA <= pinIn; syncB <= syncA; prevB <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0; cfg2 <= 3'd2; dbTime <= '0; wakeReq <= 1'b0;
      st0 <= '0; st1 <= '0; en0 <= '0; en1 <= '0; wakeMask <= '0;
      dir <= '1; dout <= '0; loEn <= '0; hiEn <= '0;
      riseEn <= '0; fallEn <= '0; dbEn <= '0;
    end else if (softRst) begin
      cfg <= merged[4:0] & CFG_KEEP; cfg2 <= 3'd2; dbTime <= '0; wakeReq <= 1'b0;
      st0 <= '0; st1 <= '0; en0 <= '0; en1 <= '0; wakeMask <= '0;
      dir <= '1; dout <= '0; loEn <= '0; hiEn <= '0;
      riseEn <= '0; fallEn <= '0; dbEn <= '0;
    end else begin
      if (stb.cfg)    cfg    <= merged[4:0] & CFG_KEEP;
      if (stb.cfg2)   cfg2   <= merged[2:0];
      if (stb.dbTime) dbTime <= merged[DBT_W-1:0];
      if (stb.dir)    dir    <= merged[PINS-1:0];
      if (stb.lo)     loEn   <= merged[PINS-1:0];
      if (stb.hi)     hiEn   <= merged[PINS-1:0];
      if (stb.rise)   riseEn <= merged[PINS-1:0];
      if (stb.fall)   fallEn <= merged[PINS-1:0];
      if (stb.dbEn)   dbEn   <= merged[PINS-1:0];

      st0 <= (st0 & ~(stb.st0Clr ? plain[PINS-1:0] : '0)) | evt;
      st1 <= (st1 & ~(stb.st1Clr ? plain[PINS-1:0] : '0)) | evt;
      wakeReq <= wakeAllowed && ((evt & ~st0 & wakeMask) != '0);

      if (stb.en0)         en0 <= merged[PINS-1:0];
      else if (stb.en0Clr) en0 <= en0 & ~plain[PINS-1:0];
      else if (stb.en0Set) en0 <= en0 | plain[PINS-1:0];

      if (stb.en1)         en1 <= merged[PINS-1:0];
      else if (stb.en1Clr) en1 <= en1 & ~plain[PINS-1:0];
      else if (stb.en1Set) en1 <= en1 | plain[PINS-1:0];

      if (stb.wake)         wakeMask <= merged[PINS-1:0];
      else if (stb.wakeClr) wakeMask <= wakeMask & ~plain[PINS-1:0];
      else if (stb.wakeSet) wakeMask <= wakeMask | plain[PINS-1:0];

      if (stb.dout)         dout <= merged[PINS-1:0];
      else if (stb.doutClr) dout <= dout & ~plain[PINS-1:0];
      else if (stb.doutSet) dout <= dout | plain[PINS-1:0];
    end
  end

  assign irqLine0    = (st0 & en0) != '0;
  assign irqLine1    = (st1 & en1) != '0;
  assign pinOut      = dout;
  assign pinOe       = ~dir;
  assign statusLine0 = st0;
  assign dirBits     = dir;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int         PINS   = 32,
  parameter int         DBT_W  = 8,
  parameter logic [7:0] REV_ID = 8'h21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic [3:0]        busByteEn,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic              irqLine0,
  output logic              irqLine1,
  output logic              wakeReq
);
  regSel_e         regSel;
  wrStrobe_t       stb;
  logic [PINS-1:0] statusLine0, dirBits;
  logic            wakeAllowed, softRst;

  gpio_bank_ctrl u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .regSel(regSel), .stb(stb)
  );

  gpio_bank_dp #(.PINS(PINS), .DBT_W(DBT_W), .REV_ID(REV_ID)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regSel(regSel),
    .busWdata(busWdata), .busByteEn(busByteEn), .pinIn(pinIn),
    .busRdata(busRdata), .pinOut(pinOut), .pinOe(pinOe),
    .irqLine0(irqLine0), .irqLine1(irqLine1), .wakeReq(wakeReq),
    .statusLine0(statusLine0), .dirBits(dirBits),
    .wakeAllowed(wakeAllowed), .softRst(softRst)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 32
) (
  input logic            clk,
  input logic            rstN,
  input wrStrobe_t       stb,
  input logic            softRst,
  input logic [PINS-1:0] statusLine0,
  input logic [PINS-1:0] dirBits,
  input logic            wakeAllowed,
  input logic            wakeReq,
  input logic            irqLine0,
  input logic            irqLine1
);
  // R10
  wake_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(wakeAllowed));

  // R9
  soft_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!irqLine0 && !irqLine1));

  // R5
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.st0Clr || softRst) |=> ((statusLine0 & $past(statusLine0)) == $past(statusLine0)));

  // R4
  output_pin_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusLine0 & ~$past(statusLine0) & ~$past(dirBits)) == '0));
endmodule

bind gpio_bank gpio_bank_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .softRst(softRst),
  .statusLine0(statusLine0), .dirBits(dirBits), .wakeAllowed(wakeAllowed),
  .wakeReq(wakeReq), .irqLine0(irqLine0), .irqLine1(irqLine1)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int PINS = 32;
  localparam logic [7:0] REV = 8'h21;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0] busByteEn = '0;
  logic [31:0] busRdata;
  logic [PINS-1:0] pinIn = '0;
  logic [PINS-1:0] pinOut, pinOe;
  logic irqLine0, irqLine1, wakeReq;

  int runCnt = 0;
  int failCnt = 0;
  int wakeCnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gpio_bank #(.PINS(PINS), .DBT_W(8), .REV_ID(REV)) u_gpio_bank (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busByteEn(busByteEn), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irqLine0(irqLine0), .irqLine1(irqLine1), .wakeReq(wakeReq)
  );

  always @(posedge clk) if (wakeReq) wakeCnt <= wakeCnt + 1;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    runCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    busAddr = a; busWdata = d; busByteEn = be; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h34, v); check("R1 dir", v, 32'hFFFF_FFFF);
    rd(8'h30, v); check("R1 cfg2", v, 32'd2);
    rd(8'h18, v); check("R1 st0", v, 32'd0);
    rd(8'h28, v); check("R1 st1", v, 32'd0);
    rd(8'h1C, v); check("R1 en0", v, 32'd0);
    rd(8'h00, v); check("R1 rev", v, {24'd0, REV});
    rd(8'h14, v); check("R1 sysstat", v, 32'd1);
    check("R1 irq", {30'd0, irqLine1, irqLine0}, 32'd0);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    wr(8'h48, 32'h1);
    pinIn[0] = 1'b1; settle();
    rd(8'h18, v); check("R2 rise st0", v, 32'h1);
    rd(8'h28, v); check("R2 rise st1", v, 32'h1);
    wr(8'h18, 32'h1); wr(8'h28, 32'h1);
    rd(8'h18, v); check("R5 w1c st0", v, 32'h0);
    wr(8'h4C, 32'h2);
    pinIn[1] = 1'b1; settle();
    rd(8'h18, v); check("R2 no rise on fall-only pin", v, 32'h0);
    pinIn[1] = 1'b0; settle();
    rd(8'h28, v); check("R2 fall st1", v, 32'h2);
    wr(8'h18, 32'h2); wr(8'h28, 32'h2);
    wr(8'h48, 32'h0); wr(8'h4C, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(8'h44, 32'h4);
    pinIn[2] = 1'b1; settle();
    rd(8'h18, v); check("R3 high level", v, 32'h4);
    wr(8'h18, 32'h4);
    rd(8'h18, v); check("R5 rearm after clear", v, 32'h4);
    pinIn[2] = 1'b0; settle();
    wr(8'h18, 32'h4); wr(8'h28, 32'h4);
    rd(8'h18, v); check("R5 clear after level gone", v, 32'h0);
    wr(8'h34, 32'hFFFF_FFF7);
    wr(8'h40, 32'h8); settle();
    rd(8'h18, v); check("R4 output pin no event", v, 32'h0);
    wr(8'h34, 32'hFFFF_FFFF); settle();
    rd(8'h18, v); check("R3 low level / R5 dir rearm", v, 32'h8);
    wr(8'h40, 32'h0); wr(8'h44, 32'h0);
    wr(8'h18, 32'h8); wr(8'h28, 32'h8);
    rd(8'h28, v); check("R5 cleared", v, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(8'h1C, 32'h10); wr(8'h48, 32'h10);
    pinIn[4] = 1'b1; settle();
    check("R6 irq0 high irq1 low", {30'd0, irqLine1, irqLine0}, 32'h1);
    wr(8'h18, 32'h10);
    check("R6 irq0 after clear", {31'd0, irqLine0}, 32'h0);
    wr(8'h74, 32'h10);
    check("R7 set alias en1 irq1", {31'd0, irqLine1}, 32'h1);
    wr(8'h70, 32'h10);
    rd(8'h2C, v); check("R7 clear alias en1", v, 32'h0);
    check("R6 irq1 low", {31'd0, irqLine1}, 32'h0);
    wr(8'h28, 32'h10); wr(8'h48, 32'h0);
  endtask

  task automatic t_out();
    logic [31:0] v;
    wr(8'h3C, 32'hA5A5_A5A5);
    wr(8'h34, 32'hFFFF_0000);
    #1 check("R4 pinOut", pinOut, 32'hA5A5_A5A5);
    check("R4 pinOe", pinOe, 32'h0000_FFFF);
    wr(8'h90, 32'h5);
    rd(8'h3C, v); check("R7 out clear alias", v, 32'hA5A5_A5A0);
    wr(8'h94, 32'hA);
    rd(8'h94, v); check("R7 out set alias", v, 32'hA5A5_A5AA);
    wr(8'h20, 32'h0F); wr(8'h80, 32'h3); wr(8'h84, 32'h30);
    rd(8'h20, v); check("R7 wake aliases", v, 32'h3C);
    wr(8'h34, 32'hFFFF_FFFF);
  endtask

  task automatic t_narrow();
    logic [31:0] v;
    wr(8'h3C, 32'h0000_5A00, 4'b0010);
    rd(8'h3C, v); check("R8 merged lane write", v, 32'hA5A5_5AAA);
    wr(8'h90, 32'hFFFF_FFFF, 4'b0001);
    rd(8'h3C, v); check("R8 alias lane only", v, 32'hA5A5_5A00);
    wr(8'h1C, 32'hFFFF_FF00, 4'b0100);
    rd(8'h1C, v); check("R8 merged enable", v, 32'h00FF_0010);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr(8'h30, 32'h7);
    rd(8'h30, v); check("R9 cfg2 write", v, 32'h7);
    wr(8'h10, 32'h0C);
    rd(8'h10, v); check("R9 cfg plain", v, 32'h0C);
    wr(8'h10, 32'hFF);
    rd(8'h10, v); check("R9 cfg mask", v, 32'h1D);
    rd(8'h30, v); check("R9 soft reset cfg2", v, 32'd2);
    rd(8'h1C, v); check("R9 soft reset en0", v, 32'd0);
    rd(8'h20, v); check("R9 soft reset wake", v, 32'd0);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_din();
    logic [31:0] v;
    logic [31:0] old;
    old = pinIn;
    @(negedge clk); pinIn = 32'h1234_5678;
    @(negedge clk); busAddr = 8'h38; #1 v = busRdata;
    check("R11 one edge old", v, old);
    @(negedge clk); #1 v = busRdata;
    check("R11 two edges new", v, 32'h1234_5678);
    wr(8'h38, 32'h0);
    rd(8'h38, v); check("R11 din write ignored", v, 32'h1234_5678);
    wr(8'h50, 32'hDEAD_BEEF);
    rd(8'h50, v); check("R11 debounce enable", v, 32'hDEAD_BEEF);
    wr(8'h54, 32'h1FF);
    rd(8'h54, v); check("R11 debounce time", v, 32'hFF);
    rd(8'h38, v); check("R11 debounce no effect", v, 32'h1234_5678);
  endtask

  task automatic t_wake();
    int base;
    pinIn = '0; settle();
    wr(8'h48, 32'h20); wr(8'h20, 32'h20);
    wr(8'h10, 32'h04);
    base = wakeCnt;
    pinIn[5] = 1'b1; settle();
    check("R10 idle field zero", wakeCnt - base, 0);
    wr(8'h18, 32'h20);
    wr(8'h10, 32'h0C);
    pinIn[5] = 1'b0; settle();
    base = wakeCnt;
    pinIn[5] = 1'b1; settle();
    check("R10 single pulse", wakeCnt - base, 1);
    check("R10 pulse ended", {31'd0, wakeReq}, 0);
    wr(8'h18, 32'h20);
    wr(8'h80, 32'h20);
    pinIn[5] = 1'b0; settle();
    base = wakeCnt;
    pinIn[5] = 1'b1; settle();
    check("R10 masked pin", wakeCnt - base, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      runCnt++;
      $display("FAIL watchdog got=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_edges();
    t_level();
    t_irq();
    t_out();
    t_narrow();
    t_cfg();
    t_din();
    t_wake();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule